// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a small byte-wide register file that sits on a simple synchronous read/write port and gathers a handful of miscellaneous system controls: a chip configuration byte, two auxiliary bytes, a diagnostic byte, a modem control byte, a system control byte and a power management location. Software selects a register with a 12-bit address field that counts in 64 KiB steps. Reads return data in the same cycle as the read strobe. Writes land on the rising clock edge.

A power-fail status input passes through a synchronizer. Each change of its synchronized level sets or clears a pending flag. The flag can only be set while the enable bit in the configuration byte is on. The flag and that enable bit together drive a level interrupt, and software acknowledges the interrupt through a separate auxiliary bit. Writes to two trigger bits produce one-cycle requests toward the shutdown logic and the system reset logic. A reset request also leaves a reset-cause value in the system control byte. The diagnostic and system control bytes are left untouched by the block's own reset, so software can read them after the restart it asked for.

Top module: `aux_sysctl_regs`

## Requirements
- R1: The register is selected by the 12-bit field `bus_addr` (address bits 27:16). The selections are 0x180 configuration, 0x190 aux-one, 0x191 aux-two, 0x1A0 diagnostic, 0x1B0 modem control, 0x1F0 system control and 0xA00 power management.
- R2: Configuration, aux-one, diagnostic and modem control are plain 8-bit registers that read back the last byte written.
- R3: While `rst_n` is low, configuration, aux-one, aux-two and modem control are cleared to 0x00. After reset, `irq_o`, `shutdown_req_o` and `reset_req_o` are low.
- R4: Diagnostic and system control keep their contents while `rst_n` is asserted.
- R5: `pwr_fail_i` is resynchronized by two flops. At every edge where the synchronized level differs from its previous value, aux-two bit 2 (pending) becomes that level ANDed with the configuration bit 3 (enable) held before the edge. The pending bit does not change at any other edge. A change of the input set up before edge k is applied at edge k+2.
- R6: `irq_o` is high exactly when aux-two bit 2 and configuration bit 3 are both 1. Clearing the enable bit lowers the interrupt but leaves the pending bit intact.
- R7: A write to aux-two stores data bit 0 into bit 0. A data bit 1 of 1 clears pending bit 2; otherwise bit 2 keeps its value. Bit 1 and bits 7:3 always read 0. A synchronized power-fail change at the same edge takes priority for bit 2.
- R8: A write to aux-two with data bit 0 set raises `shutdown_req_o` for exactly the one cycle that follows the write edge.
- R9: A write to system control with data bit 0 set loads 0x02 and raises `reset_req_o` for exactly the one cycle that follows the write edge. A write with bit 0 clear changes nothing and raises no request.
- R10: The power management location and every undecoded field read 0x00. Writes to them change no register.
- R11: `bus_rdata` is combinational from the address during `bus_re` and reads 0x00 when `bus_re` is low. A read in the same cycle as a write returns the value held before that write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register select field (address bits 27:16) |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| pwr_fail_i | input | 1 | Asynchronous power-fail status |
| irq_o | output | 1 | Power-fail interrupt, level |
| shutdown_req_o | output | 1 | One-cycle shutdown request |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench times the power-fail path against the synchronizer depth. A design with a missing or extra stage would raise the interrupt one edge early or late. It also checks that a pending flag survives a toggle of the enable bit, and that a steady input is not resampled when the enable bit is turned back on. A design that resampled every cycle would either refuse the acknowledge while the input stays high or raise the interrupt with no new event. The reset-cause and retained bytes are checked across a block reset, which catches a design that resets every register. The bench also writes system control with bit 0 clear and reads it back, which catches a design that stores such writes.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;

    localparam int FIELD_W = 12;

    localparam logic [FIELD_W-1:0] OFF_CFG   = 12'h180;
    localparam logic [FIELD_W-1:0] OFF_AUX1  = 12'h190;
    localparam logic [FIELD_W-1:0] OFF_AUX2  = 12'h191;
    localparam logic [FIELD_W-1:0] OFF_DIAG  = 12'h1A0;
    localparam logic [FIELD_W-1:0] OFF_MODEM = 12'h1B0;
    localparam logic [FIELD_W-1:0] OFF_SYS   = 12'h1F0;
    localparam logic [FIELD_W-1:0] OFF_PMGT  = 12'hA00;

    localparam int PF_EN_BIT   = 3;   // configuration: power-fail enable
    localparam int OFF_BIT     = 0;   // aux-two: shutdown trigger / stored bit
    localparam int ACK_BIT     = 1;   // aux-two: pending acknowledge
    localparam int PEND_BIT    = 2;   // aux-two: power-fail pending
    localparam int SYS_GO_BIT  = 0;   // system control: reset trigger
    localparam logic [7:0] RST_CAUSE = 8'h02;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_AUX1,
        SEL_AUX2,
        SEL_DIAG,
        SEL_MODEM,
        SEL_SYS,
        SEL_PMGT
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] cfg;
        logic [7:0] aux1;
        logic [7:0] modem;
        logic       pend;
        logic       off;
        logic       pf_prev;
        logic       shut;
        logic       rreq;
    } live_t;

    typedef struct packed {
        logic [7:0] diag;
        logic [7:0] sysctl;
    } keep_t;

endpackage

// File: rtl/aux_sysctl_decode.sv
module aux_sysctl_decode
    import aux_sysctl_pkg::*;
#(
    parameter int SEL_W = FIELD_W
) (
    input  logic [SEL_W-1:0] field,
    output reg_sel_e         sel
);
    always_comb begin
        sel = SEL_NONE;
        unique case (field)
            SEL_W'(OFF_CFG):   sel = SEL_CFG;
            SEL_W'(OFF_AUX1):  sel = SEL_AUX1;
            SEL_W'(OFF_AUX2):  sel = SEL_AUX2;
            SEL_W'(OFF_DIAG):  sel = SEL_DIAG;
            SEL_W'(OFF_MODEM): sel = SEL_MODEM;
            SEL_W'(OFF_SYS):   sel = SEL_SYS;
            SEL_W'(OFF_PMGT):  sel = SEL_PMGT;
            default:           sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/aux_sysctl_sync.sv
module aux_sysctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/aux_sysctl_core.sv
module aux_sysctl_core
    import aux_sysctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  reg_sel_e   sel,
    input  logic [7:0] wdata,
    input  logic       we,
    input  logic       re,
    input  logic       pf_sync,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       shut_req,
    output logic       rst_req,
    output logic       pf_event
);
    live_t live_d, live_q;
    keep_t keep_d, keep_q;

    always_comb begin
        live_d      = live_q;
        keep_d      = keep_q;
        live_d.shut = 1'b0;
        live_d.rreq = 1'b0;
        pf_event    = (pf_sync != live_q.pf_prev);

        if (we) begin
            unique case (sel)
                SEL_CFG:   live_d.cfg   = wdata;
                SEL_AUX1:  live_d.aux1  = wdata;
                SEL_MODEM: live_d.modem = wdata;
                SEL_DIAG:  keep_d.diag  = wdata;
                SEL_AUX2: begin
                    live_d.off  = wdata[OFF_BIT];
                    live_d.shut = wdata[OFF_BIT];
                    if (wdata[ACK_BIT]) live_d.pend = 1'b0;
                end
                SEL_SYS: begin
                    if (wdata[SYS_GO_BIT]) begin
                        keep_d.sysctl = RST_CAUSE;
                        live_d.rreq   = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (pf_event) live_d.pend = pf_sync & live_q.cfg[PF_EN_BIT];
        live_d.pf_prev = pf_sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    always_ff @(posedge clk) keep_q <= keep_d;

    always_comb begin
        rdata = 8'h00;
        if (re) begin
            unique case (sel)
                SEL_CFG:   rdata = live_q.cfg;
                SEL_AUX1:  rdata = live_q.aux1;
                SEL_MODEM: rdata = live_q.modem;
                SEL_DIAG:  rdata = keep_q.diag;
                SEL_SYS:   rdata = keep_q.sysctl;
                SEL_AUX2: begin
                    rdata[OFF_BIT]  = live_q.off;
                    rdata[PEND_BIT] = live_q.pend;
                end
                default:   rdata = 8'h00;
            endcase
        end
    end

    assign irq      = live_q.pend & live_q.cfg[PF_EN_BIT];
    assign shut_req = live_q.shut;
    assign rst_req  = live_q.rreq;
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
    import aux_sysctl_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int FIELD_LSB = 16,
    parameter int SYNC_N    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:FIELD_LSB]   bus_addr,
    input  logic [7:0]                  bus_wdata,
    input  logic                        bus_we,
    input  logic                        bus_re,
    output logic [7:0]                  bus_rdata,
    input  logic                        pwr_fail_i,
    output logic                        irq_o,
    output logic                        shutdown_req_o,
    output logic                        reset_req_o
);
    localparam int SEL_W = ADDR_W - FIELD_LSB;

    reg_sel_e sel_w;
    logic     pf_sync_w;
    logic     pf_event_w;

    aux_sysctl_decode #(.SEL_W(SEL_W)) u_dec (
        .field (bus_addr),
        .sel   (sel_w)
    );

    aux_sysctl_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pwr_fail_i),
        .sync_o  (pf_sync_w)
    );

    aux_sysctl_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_w),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .re       (bus_re),
        .pf_sync  (pf_sync_w),
        .rdata    (bus_rdata),
        .irq      (irq_o),
        .shut_req (shutdown_req_o),
        .rst_req  (reset_req_o),
        .pf_event (pf_event_w)
    );
endmodule

// File: rtl/aux_sysctl_chk.sv
module aux_sysctl_chk #(
    parameter int SEL_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] addr,
    input logic [7:0]       wdata,
    input logic             we,
    input logic             re,
    input logic [7:0]       rdata,
    input logic             irq,
    input logic             shut,
    input logic             rreq,
    input logic             pf_event
);
    logic hit_aux2, hit_sys, hit_pmgt;
    assign hit_aux2 = (addr == SEL_W'(12'h191));
    assign hit_sys  = (addr == SEL_W'(12'h1F0));
    assign hit_pmgt = (addr == SEL_W'(12'hA00));

    assert_shut_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_aux2 && wdata[0]) |=> shut);
    assert_shut_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shut |=> !shut);
    assert_rreq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_sys && wdata[0]) |=> rreq);
    assert_rreq_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rreq |-> $past(we && hit_sys && wdata[0]));
    assert_ack_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_aux2 && wdata[1] && !pf_event) |=> !irq);
    assert_pmgt_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (re && hit_pmgt) |-> (rdata == 8'h00));
    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !re |-> (rdata == 8'h00));
endmodule

bind aux_sysctl_regs aux_sysctl_chk #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .we       (bus_we),
    .re       (bus_re),
    .rdata    (bus_rdata),
    .irq      (irq_o),
    .shut     (shutdown_req_o),
    .rreq     (reset_req_o),
    .pf_event (pf_event_w)
);

// File: tb/sim_aux_sysctl_regs.sv
`timescale 1ns/1ps
module sim_aux_sysctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        pwr_fail_i = 1'b0;
    logic        irq_o, shutdown_req_o, reset_req_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    aux_sysctl_regs u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_we         (bus_we),
        .bus_re         (bus_re),
        .bus_rdata      (bus_rdata),
        .pwr_fail_i     (pwr_fail_i),
        .irq_o          (irq_o),
        .shutdown_req_o (shutdown_req_o),
        .reset_req_o    (reset_req_o)
    );

    // vector: {requirement tag number, write flag, field, data or expected read}
    localparam int NV = 14;
    localparam logic [24:0] VEC [NV] = '{
        {4'd2,  1'b1, 12'h180, 8'hA5},
        {4'd2,  1'b0, 12'h180, 8'hA5},
        {4'd2,  1'b1, 12'h190, 8'h3C},
        {4'd2,  1'b0, 12'h190, 8'h3C},
        {4'd2,  1'b1, 12'h1A0, 8'hC3},
        {4'd2,  1'b0, 12'h1A0, 8'hC3},
        {4'd2,  1'b1, 12'h1B0, 8'h7E},
        {4'd2,  1'b0, 12'h1B0, 8'h7E},
        {4'd10, 1'b1, 12'hA00, 8'hFF},
        {4'd10, 1'b0, 12'hA00, 8'h00},
        {4'd10, 1'b0, 12'h123, 8'h00},
        {4'd7,  1'b1, 12'h191, 8'hFC},
        {4'd7,  1'b0, 12'h191, 8'h00},
        {4'd1,  1'b0, 12'h180, 8'hA5}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R3: reset state
        do_read(12'h180, rd); check("R3 cfg", rd, 8'h00);
        do_read(12'h190, rd); check("R3 aux1", rd, 8'h00);
        do_read(12'h191, rd); check("R3 aux2", rd, 8'h00);
        do_read(12'h1B0, rd); check("R3 modem", rd, 8'h00);
        check("R3 outputs", {5'd0, irq_o, shutdown_req_o, reset_req_o}, 8'h00);

        // R1 R2 R7 R10: vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) do_write(VEC[i][19:8], VEC[i][7:0]);
            else begin
                do_read(VEC[i][19:8], rd);
                check($sformatf("R%0d vec%0d", VEC[i][24:21], i), rd, VEC[i][7:0]);
            end
        end

        // R11: idle strobe reads zero; same-cycle read returns old value
        @(negedge clk); bus_addr = 12'h190; #1;
        check("R11 idle rdata", bus_rdata, 8'h00);
        bus_we = 1'b1; bus_wdata = 8'h11; bus_re = 1'b1; #1;
        check("R11 pre-edge read", bus_rdata, 8'h3C);
        @(posedge clk); #1;
        check("R11 post-edge read", bus_rdata, 8'h11);
        bus_we = 1'b0; bus_re = 1'b0;

        // R9: system control trigger, cause code, pulse
        do_write(12'h1F0, 8'h01);
        check("R9 reset pulse", {7'd0, reset_req_o}, 8'h01);
        @(posedge clk); #1;
        check("R9 reset pulse width", {7'd0, reset_req_o}, 8'h00);
        do_read(12'h1F0, rd); check("R9 cause", rd, 8'h02);
        do_write(12'h1F0, 8'hFE);
        check("R9 no pulse", {7'd0, reset_req_o}, 8'h00);
        do_read(12'h1F0, rd); check("R9 unchanged", rd, 8'h02);

        // R4: retained bytes across block reset
        do_write(12'h1A0, 8'h99);
        do_write(12'h180, 8'h08);
        pulse_reset();
        do_read(12'h1A0, rd); check("R4 diag kept", rd, 8'h99);
        do_read(12'h1F0, rd); check("R4 sysctl kept", rd, 8'h02);
        do_read(12'h180, rd); check("R3 cfg cleared", rd, 8'h00);
        do_read(12'h190, rd); check("R3 aux1 cleared", rd, 8'h00);

        // R8: shutdown pulse
        do_write(12'h191, 8'h01);
        check("R8 shutdown pulse", {7'd0, shutdown_req_o}, 8'h01);
        @(posedge clk); #1;
        check("R8 shutdown width", {7'd0, shutdown_req_o}, 8'h00);
        do_read(12'h191, rd); check("R7 off bit stored", rd, 8'h01);
        do_write(12'h191, 8'h00);
        check("R8 no shutdown", {7'd0, shutdown_req_o}, 8'h00);

        // R5 R6: latency through synchronizer
        do_write(12'h180, 8'h08);
        @(negedge clk); pwr_fail_i = 1'b1;
        repeat (2) @(posedge clk); #1;
        check("R5 not yet", {7'd0, irq_o}, 8'h00);
        @(posedge clk); #1;
        check("R5 irq set", {7'd0, irq_o}, 8'h01);
        do_read(12'h191, rd); check("R5 pending", rd, 8'h04);

        // R7: keep pending on plain write, ack clears it
        do_write(12'h191, 8'h01);
        do_read(12'h191, rd); check("R7 keep pending", rd, 8'h05);
        do_write(12'h191, 8'h02);
        do_read(12'h191, rd); check("R7 ack clears", rd, 8'h00);
        check("R7 irq after ack", {7'd0, irq_o}, 8'h00);

        // R5: no event while level steady; enable gating
        do_write(12'h180, 8'h00);
        do_write(12'h180, 8'h08);
        repeat (4) @(posedge clk); #1;
        check("R5 steady no resample", {7'd0, irq_o}, 8'h00);
        @(negedge clk); pwr_fail_i = 1'b0;
        do_write(12'h180, 8'h00);
        repeat (4) @(posedge clk);
        @(negedge clk); pwr_fail_i = 1'b1;
        repeat (4) @(posedge clk); #1;
        do_read(12'h191, rd); check("R5 disabled no pending", rd, 8'h00);

        // R6: enable toggle keeps pending
        @(negedge clk); pwr_fail_i = 1'b0;
        do_write(12'h180, 8'h08);
        repeat (4) @(posedge clk);
        @(negedge clk); pwr_fail_i = 1'b1;
        repeat (4) @(posedge clk); #1;
        check("R6 irq on", {7'd0, irq_o}, 8'h01);
        do_write(12'h180, 8'h00);
        check("R6 irq off by enable", {7'd0, irq_o}, 8'h00);
        do_read(12'h191, rd); check("R6 pending kept", rd, 8'h04);
        do_write(12'h180, 8'h08);
        check("R6 irq back", {7'd0, irq_o}, 8'h01);

        // R5: falling input clears pending
        @(negedge clk); pwr_fail_i = 1'b0;
        repeat (3) @(posedge clk); #1;
        check("R5 clear on fall", {7'd0, irq_o}, 8'h00);
        do_read(12'h191, rd); check("R5 pending cleared", rd, 8'h00);

        finish_run();
    end
endmodule